// File: doc/BRIEF.md
# Transmit Packet Framer with Header, Payload and Footer Beats

The block turns one transmit request into one framed packet on an active-low source/destination ready interface. A request carries five 32-bit application header words and a payload length in bytes. Once the request is accepted, the framer sends the five header words, then streams the payload words it pulls from an upstream word stream, then sends one closing footer beat. The first header beat is marked as start of frame. The first payload beat is marked as start of payload. The last payload beat is marked as end of payload and carries a mask of its unused byte lanes. The footer beat is marked as end of frame.

Both the framer and the downstream receiver can pause the packet on any cycle. The framer pauses when the upstream payload stream has no word ready. A beat moves only when both ready lines are low. A request with a zero byte length is refused with a one-cycle error pulse, and no packet is sent. The framer takes the next request only after the footer beat has been transferred.

Top module: `ll_tx_framer`

## Requirements
- R1: While reset is held and after it is released, with no request, ll_src_rdy_n, ll_sof_n, ll_sop_n, ll_eop_n and ll_eof_n are all high, ll_rem is 4'b0000, and req_ready is high.
- R2: A beat is transferred only on a cycle where ll_src_rdy_n and ll_dst_rdy_n are both low. Under any pattern of receiver stalls and upstream gaps, every header and payload word is delivered exactly once and in order.
- R3: The first five transferred beats carry the header words APP0 to APP4, in that order. APP0 is req_app[31:0] and APPk is req_app[32k+31:32k]. ll_sof_n is low on the APP0 beat only.
- R4: ll_sop_n is low on the first payload beat only. That beat carries the first payload word with all 32 bits.
- R5: For a byte length L of at least 1, the packet has exactly 5 + ceil(L/4) + 1 transferred beats.
- R6: ll_eop_n is low on the last payload beat only. On that beat ll_rem[0:3] has a 1 for each unused byte lane. Lane 0 is ll_data[31:24]. With v = L mod 4 (4 when that is 0), the mask is 0111 for v=1, 0011 for v=2, 0001 for v=3 and 0000 for v=4.
- R7: ll_rem is 4'b0000 on every beat where ll_eop_n is high.
- R8: The beat transferred right after the end-of-payload beat is the footer. It has ll_eof_n low and ll_sof_n, ll_sop_n and ll_eop_n high. ll_eof_n is high on every other beat.
- R9: req_ready is low from the cycle after a non-zero request is accepted until the footer beat has been transferred.
- R10: A request with req_len of zero makes req_err high for exactly the one cycle after acceptance. No beat is sent, and req_ready stays high.
- R11: While ll_src_rdy_n is low and the receiver holds ll_dst_rdy_n high, ll_data, ll_rem and the four frame markers stay unchanged into the next cycle whenever ll_src_rdy_n is still low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Transmit request present |
| req_ready | output | 1 | Framer idle and taking a request |
| req_app | input | 160 | Five header words, APP0 in the low 32 bits |
| req_len | input | 16 | Payload length in bytes |
| req_err | output | 1 | One-cycle pulse after a zero-length request |
| pl_valid | input | 1 | Upstream payload word available |
| pl_ready | output | 1 | Payload word taken this cycle when pl_valid is high |
| pl_data | input | 32 | Upstream payload word, lane 0 in bits 31:24 |
| ll_data | output | 32 | Beat data |
| ll_rem | output | 4 | Unused-lane mask, declared [0:3] |
| ll_sof_n | output | 1 | Start of frame, active low |
| ll_sop_n | output | 1 | Start of payload, active low |
| ll_eop_n | output | 1 | End of payload, active low |
| ll_eof_n | output | 1 | End of frame, active low |
| ll_src_rdy_n | output | 1 | Framer has a beat, active low |
| ll_dst_rdy_n | input | 1 | Receiver can take a beat, active low |

## Verification
The bench runs lengths of 1, 4, 6, 11, 16 and 37 bytes. These cover every tail mask and the single-word payload, where start and end of payload fall on the same beat. A framer that computes the mask from the wrong end, or leaves it set off the last beat, fails the mask checks. A word count that rounds down loses the tail word. Random receiver stalls combined with upstream gaps expose a framer that advances on its own ready instead of on the joint handshake, which would drop or repeat words or change data during a stall. A zero-length request and the ready line during a packet catch a framer that sends an empty packet or accepts a second request before the footer.

// File: rtl/ll_tx_pkg.sv
package ll_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_PAY  = 2'd2,
    ST_FTR  = 2'd3
  } tx_state_e;
endpackage

// File: rtl/ll_tx_len_calc.sv
module ll_tx_len_calc #(
  parameter int LEN_W  = 16,
  parameter int LANES  = 4,
  parameter int LG     = $clog2(LANES),
  parameter int WCNT_W = LEN_W - LG + 1
) (
  input  logic [LEN_W-1:0]  len,
  output logic [WCNT_W-1:0] words,
  output logic [0:LANES-1]  tail_mask,
  output logic              is_zero
);
  logic [LEN_W:0] sum;
  logic [LG-1:0]  tail;
  logic [LG:0]    vcnt;

  assign sum     = {1'b0, len} + (LEN_W+1)'(LANES - 1);
  assign words   = WCNT_W'(sum >> LG);
  assign tail    = len[LG-1:0];
  assign vcnt    = (tail == '0) ? (LG+1)'(LANES) : {1'b0, tail};
  assign is_zero = (len == '0);

  // lane k is unused when its index reaches the count of valid bytes
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign tail_mask[k] = ((LG+1)'(k) >= vcnt);
  end
endmodule

// File: rtl/ll_tx_hdr_sel.sv
module ll_tx_hdr_sel #(
  parameter int DATA_W = 32,
  parameter int N      = 5,
  parameter int IDX_W  = $clog2(N + 1)
) (
  input  logic [N*DATA_W-1:0] words,
  input  logic [IDX_W-1:0]    idx,
  output logic [DATA_W-1:0]   word
);
  logic [DATA_W-1:0] slot [N];

  for (genvar g = 0; g < N; g++) begin : g_slot
    assign slot[g] = words[g*DATA_W +: DATA_W];
  end

  always_comb begin
    word = '0;
    for (int i = 0; i < N; i++) begin
      if (idx == IDX_W'(i)) word = slot[i];
    end
  end
endmodule

// File: rtl/ll_tx_framer.sv
module ll_tx_framer
  import ll_tx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int APP_N  = 5,
  parameter int LEN_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [APP_N*DATA_W-1:0] req_app,
  input  logic [LEN_W-1:0]        req_len,
  output logic                    req_err,
  input  logic                    pl_valid,
  output logic                    pl_ready,
  input  logic [DATA_W-1:0]       pl_data,
  output logic [DATA_W-1:0]       ll_data,
  output logic [0:DATA_W/8-1]     ll_rem,
  output logic                    ll_sof_n,
  output logic                    ll_sop_n,
  output logic                    ll_eop_n,
  output logic                    ll_eof_n,
  output logic                    ll_src_rdy_n,
  input  logic                    ll_dst_rdy_n
);
  localparam int LANES  = DATA_W / 8;
  localparam int LG     = $clog2(LANES);
  localparam int WCNT_W = LEN_W - LG + 1;
  localparam int IDX_W  = $clog2(APP_N + 1);

  // reset: asserted at once, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  tx_state_e                 state_q, state_d;
  logic [IDX_W-1:0]          idx_q, idx_d;
  logic [WCNT_W-1:0]         wleft_q, wleft_d;
  logic                      first_q, first_d;
  logic [0:LANES-1]          mask_q;
  logic [APP_N*DATA_W-1:0]   app_q;
  logic                      err_q, err_d;
  logic                      load_en;

  logic [WCNT_W-1:0]         req_words;
  logic [0:LANES-1]          req_mask;
  logic                      req_zero;
  logic [DATA_W-1:0]         hdr_word;
  logic                      xfer;
  logic                      last_word;

  ll_tx_len_calc #(.LEN_W(LEN_W), .LANES(LANES)) u_len (
    .len       (req_len),
    .words     (req_words),
    .tail_mask (req_mask),
    .is_zero   (req_zero)
  );

  ll_tx_hdr_sel #(.DATA_W(DATA_W), .N(APP_N)) u_hdr (
    .words (app_q),
    .idx   (idx_q),
    .word  (hdr_word)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign req_err   = err_q;
  assign last_word = (wleft_q == WCNT_W'(1));
  assign xfer      = !ll_src_rdy_n && !ll_dst_rdy_n;
  assign pl_ready  = (state_q == ST_PAY) && !ll_dst_rdy_n;

  // beat outputs
  always_comb begin
    ll_data      = '0;
    ll_rem       = '0;
    ll_sof_n     = 1'b1;
    ll_sop_n     = 1'b1;
    ll_eop_n     = 1'b1;
    ll_eof_n     = 1'b1;
    ll_src_rdy_n = 1'b1;
    unique case (state_q)
      ST_HDR: begin
        ll_data      = hdr_word;
        ll_src_rdy_n = 1'b0;
        ll_sof_n     = (idx_q != '0);
      end
      ST_PAY: begin
        ll_data      = pl_data;
        ll_src_rdy_n = !pl_valid;
        ll_sop_n     = !first_q;
        ll_eop_n     = !last_word;
        ll_rem       = last_word ? mask_q : '0;
      end
      ST_FTR: begin
        ll_src_rdy_n = 1'b0;
        ll_eof_n     = 1'b0;
      end
      default: ;
    endcase
  end

  // next state
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    wleft_d = wleft_q;
    first_d = first_q;
    err_d   = 1'b0;
    load_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (req_zero) begin
            err_d = 1'b1;
          end else begin
            load_en = 1'b1;
            state_d = ST_HDR;
            idx_d   = '0;
            wleft_d = req_words;
            first_d = 1'b1;
          end
        end
      end
      ST_HDR: begin
        if (xfer) begin
          if (idx_q == IDX_W'(APP_N - 1)) state_d = ST_PAY;
          else                            idx_d   = idx_q + 1'b1;
        end
      end
      ST_PAY: begin
        if (xfer) begin
          first_d = 1'b0;
          wleft_d = wleft_q - 1'b1;
          if (last_word) state_d = ST_FTR;
        end
      end
      ST_FTR: begin
        if (xfer) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      wleft_q <= '0;
      first_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      wleft_q <= wleft_d;
      first_q <= first_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      app_q  <= '0;
      mask_q <= '0;
    end else if (load_en) begin
      app_q  <= req_app;
      mask_q <= req_mask;
    end
  end
endmodule

// File: rtl/ll_tx_framer_chk.sv
module ll_tx_framer_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              req_err,
  input logic [DATA_W-1:0] ll_data,
  input logic [0:DATA_W/8-1] ll_rem,
  input logic              ll_sof_n,
  input logic              ll_sop_n,
  input logic              ll_eop_n,
  input logic              ll_eof_n,
  input logic              ll_src_rdy_n,
  input logic              ll_dst_rdy_n
);
  AST_REM_CLEAR_OFF_EOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!ll_src_rdy_n && ll_eop_n) |-> (ll_rem == '0));  // R7

  AST_FOOTER_AFTER_EOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!ll_src_rdy_n && !ll_dst_rdy_n && !ll_eop_n) |=> (!ll_src_rdy_n && !ll_eof_n));  // R8

  AST_FOOTER_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ll_src_rdy_n && !ll_eof_n) |-> (ll_eop_n && ll_sop_n && ll_sof_n && ll_rem == '0));  // R8

  AST_SOF_NOT_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ll_src_rdy_n && !ll_sof_n) |-> (ll_sop_n && ll_eop_n && ll_eof_n));  // R3

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!ll_src_rdy_n && $past(!ll_src_rdy_n && ll_dst_rdy_n)) |->
      ($stable(ll_data) && $stable(ll_rem) && $stable(ll_sof_n) &&
       $stable(ll_sop_n) && $stable(ll_eop_n) && $stable(ll_eof_n)));  // R11

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !ll_src_rdy_n |-> !req_ready);  // R9

  AST_ERR_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> (ll_src_rdy_n && req_ready));  // R10
endmodule

bind ll_tx_framer ll_tx_framer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .req_err      (req_err),
  .ll_data      (ll_data),
  .ll_rem       (ll_rem),
  .ll_sof_n     (ll_sof_n),
  .ll_sop_n     (ll_sop_n),
  .ll_eop_n     (ll_eop_n),
  .ll_eof_n     (ll_eof_n),
  .ll_src_rdy_n (ll_src_rdy_n),
  .ll_dst_rdy_n (ll_dst_rdy_n)
);

// File: tb/sim_ll_tx_framer.sv
`timescale 1ns/1ps
module sim_ll_tx_framer;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid;
  logic         req_ready;
  logic [159:0] req_app;
  logic [15:0]  req_len;
  logic         req_err;
  logic         pl_valid;
  logic         pl_ready;
  logic [31:0]  pl_data;
  logic [31:0]  ll_data;
  logic [0:3]   ll_rem;
  logic         ll_sof_n, ll_sop_n, ll_eop_n, ll_eof_n, ll_src_rdy_n, ll_dst_rdy_n;

  always #10 clk = ~clk;

  ll_tx_framer u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_app(req_app), .req_len(req_len), .req_err(req_err),
    .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_data(pl_data),
    .ll_data(ll_data), .ll_rem(ll_rem), .ll_sof_n(ll_sof_n), .ll_sop_n(ll_sop_n),
    .ll_eop_n(ll_eop_n), .ll_eof_n(ll_eof_n), .ll_src_rdy_n(ll_src_rdy_n),
    .ll_dst_rdy_n(ll_dst_rdy_n)
  );

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  // beat record
  logic [31:0] bd   [0:63];
  logic [0:3]  brem [0:63];
  logic        bsof [0:63];
  logic        bsop [0:63];
  logic        beop [0:63];
  logic        beof [0:63];
  int          nbeats = 0;
  bit          eof_got = 0;

  // payload source
  logic [31:0] src_words [0:63];
  int          src_n = 0;
  int          src_i = 0;
  bit          hs_seen = 0;
  bit          stalls = 0;
  bit          bubbles = 0;
  logic [15:0] lfsr = 16'hACE1;

  // monitor state
  bit          prev_stall = 0;
  logic [31:0] p_data;
  logic [0:3]  p_rem;
  logic [3:0]  p_flags;
  int          stall_bad = 0;
  int          busy_bad = 0;
  bit          busy = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (!ll_src_rdy_n && prev_stall) begin
        if (ll_data != p_data || ll_rem != p_rem ||
            {ll_sof_n, ll_sop_n, ll_eop_n, ll_eof_n} != p_flags) stall_bad++;
      end
      prev_stall = !ll_src_rdy_n && ll_dst_rdy_n;
      p_data  = ll_data;
      p_rem   = ll_rem;
      p_flags = {ll_sof_n, ll_sop_n, ll_eop_n, ll_eof_n};
      if (busy && req_ready) busy_bad++;
      if (req_valid && req_ready && req_len != 0) busy = 1;
      if (pl_valid && pl_ready) hs_seen = 1;
      if (!ll_src_rdy_n && !ll_dst_rdy_n) begin
        if (nbeats < 64) begin
          bd[nbeats]   = ll_data;
          brem[nbeats] = ll_rem;
          bsof[nbeats] = ll_sof_n;
          bsop[nbeats] = ll_sop_n;
          beop[nbeats] = ll_eop_n;
          beof[nbeats] = ll_eof_n;
        end
        nbeats++;
        if (!ll_eof_n) begin
          eof_got = 1;
          busy = 0;
        end
      end
    end
  end

  // receiver stall and payload source drivers
  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    ll_dst_rdy_n = stalls ? (lfsr[0] & lfsr[2]) | lfsr[5] : 1'b0;
    if (hs_seen) begin
      hs_seen  = 0;
      src_i++;
      pl_valid = 1'b0;
    end
    if (!pl_valid && src_i < src_n) begin
      pl_valid = bubbles ? lfsr[7] : 1'b1;
      pl_data  = src_words[src_i];
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, 100000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic send_req(input int len, input int seed);
    @(posedge clk); #2;
    for (int k = 0; k < 5; k++) req_app[k*32 +: 32] = 32'hA000_0000 + seed * 16 + k;
    req_len   = 16'(len);
    req_valid = 1'b1;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #2;
    req_valid = 1'b0;
  endtask

  task automatic run_pkt(input int len, input bit st, input bit bb);
    int nw = (len + 3) / 4;
    int tail = (len % 4 == 0) ? 4 : len % 4;
    logic [0:3] exp_rem = 4'b1111 >> tail;
    int sb0 = stall_bad;
    int bb0 = busy_bad;
    bit ok;
    int t = 0;
    stalls = st; bubbles = bb;
    nbeats = 0; eof_got = 0;
    src_i = 0;
    for (int i = 0; i < nw; i++) src_words[i] = 32'h5A00_0000 + len * 256 + i;
    src_n = nw;
    send_req(len, len);
    while (!eof_got && t < 3000) begin @(negedge clk); t++; end
    stalls = 0; bubbles = 0;
    chk(nbeats == 5 + nw + 1, "R5", $sformatf("beat count len=%0d", len), nbeats, 5 + nw + 1);
    if (nbeats != 5 + nw + 1) return;
    ok = 1;
    for (int k = 0; k < 5; k++)
      if (bd[k] != 32'hA000_0000 + len * 16 + k || bsof[k] != (k != 0)) ok = 0;
    for (int k = 5; k < 6 + nw; k++) if (!bsof[k]) ok = 0;
    chk(ok, "R3", $sformatf("header words/sof len=%0d", len), bd[0], 32'hA000_0000 + len * 16);
    ok = 1;
    for (int i = 0; i < nw; i++) if (bd[5+i] != src_words[i]) ok = 0;
    chk(ok, "R2", $sformatf("payload order len=%0d", len), bd[5], src_words[0]);
    ok = 1;
    for (int k = 0; k < 6 + nw; k++) if (bsop[k] != (k != 5)) ok = 0;
    chk(ok, "R4", $sformatf("sop on first payload len=%0d", len), bsop[5], 0);
    ok = 1;
    for (int k = 0; k < 6 + nw; k++) if (beop[k] != (k != 4 + nw)) ok = 0;
    chk(ok && brem[4+nw] == exp_rem, "R6", $sformatf("eop/rem len=%0d", len), brem[4+nw], exp_rem);
    ok = 1;
    for (int k = 0; k < 6 + nw; k++) if (k != 4 + nw && brem[k] != 4'b0000) ok = 0;
    chk(ok, "R7", $sformatf("rem zero off eop len=%0d", len), ok, 1);
    ok = 1;
    for (int k = 0; k < 6 + nw; k++) if (beof[k] != (k != 5 + nw)) ok = 0;
    chk(ok, "R8", $sformatf("footer eof len=%0d", len), beof[5+nw], 0);
    chk(stall_bad == sb0, "R11", $sformatf("hold under stall len=%0d", len), stall_bad - sb0, 0);
    chk(busy_bad == bb0, "R9", $sformatf("ready low while busy len=%0d", len), busy_bad - bb0, 0);
  endtask

  task automatic run_zero_len();
    nbeats = 0;
    send_req(0, 99);
    @(negedge clk);
    chk(req_err == 1'b1, "R10", "err pulse after zero len", req_err, 1);
    @(negedge clk);
    chk(req_err == 1'b0, "R10", "err pulse one cycle", req_err, 0);
    repeat (10) @(negedge clk);
    chk(nbeats == 0 && ll_src_rdy_n, "R10", "no beat after zero len", nbeats, 0);
    chk(req_ready == 1'b1, "R10", "ready after zero len", req_ready, 1);
  endtask

  task automatic run_reset();
    repeat (3) @(negedge clk);
    chk(ll_src_rdy_n && ll_sof_n && ll_sop_n && ll_eop_n && ll_eof_n && ll_rem == 4'b0000,
        "R1", "outputs in reset", {ll_src_rdy_n, ll_sof_n, ll_sop_n, ll_eop_n, ll_eof_n}, 5'h1f);
    @(posedge clk); #2 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ll_src_rdy_n && ll_sof_n && ll_eof_n && req_ready && !req_err,
        "R1", "idle after reset", {ll_src_rdy_n, req_ready}, 2'b11);
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_app = '0;
    req_len = '0;
    pl_valid = 1'b0;
    pl_data = '0;
    ll_dst_rdy_n = 1'b0;
    run_reset();
    run_pkt(1, 0, 0);
    run_pkt(4, 0, 0);
    run_pkt(6, 1, 0);
    run_pkt(11, 0, 1);
    run_zero_len();
    run_pkt(37, 1, 1);
    run_pkt(16, 1, 1);
    run_pkt(3, 0, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule